// File: doc/BRIEF.md
# System MMU Control and Fault Register Block

This block is the software-facing register file of a system MMU. It holds the mode control, a free configuration word, the translation table base, the fault interrupt status with write-one-to-clear, and four captured fault addresses. It also drives the mode the translation datapath runs in, and issues TLB invalidate commands. The datapath itself lives elsewhere. It reports faults to this block as a type and an address, and it reports when it has drained its traffic.

Control has three meaningful values. 0x0 turns the MMU off, 0x5 makes it translate, and 0x7 stalls new requests. Once a stall has been requested and the datapath reports idle, bit 0 of the status word reads 1. An accepted fault sets its interrupt status bit and records its address. In the same cycle it forces the stall bit, so the MMU stays blocked until software writes 0x5 again. The interrupt line is the OR of all pending status bits.

Bus reads return data one cycle after the read strobe. Writes take effect at the clock edge that samples them.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset, control, configuration, table base, interrupt status, fault addresses and read data are all zero. The irq, translate, stall and flush outputs are low. Offset 0x034 reads the VERSION_ID parameter (default 0x3000_0001).
- R2: Offset 0x000 stores bits [2:0] of a write. Bit 0 is enable and bit 1 is block. The translate output is high when enable=1 and block=0. The stall output is high when enable=1 and block=1.
- R3: Status offset 0x008 bit 0 becomes 1 one cycle after a cycle in which control has enable and block set and the datapath idle input is high. It then stays 1 until enable or block clears, and it drops one cycle after that.
- R4: A fault input accepted at an edge sets interrupt status bit [type] at offset 0x018 and sets the control block bit at the same edge. The irq output is high while any status bit is 1. Status bit positions: 0 page, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection.
- R5: An accepted fault records its address in one register, chosen by type. Type 0 goes to 0x024. Types 2, 6 and 7 go to 0x028. Types 1, 4 and 5 go to 0x02C. Type 3 goes to 0x030.
- R6: Writing a mask to 0x01C clears each status bit whose mask bit is 1. A fault arriving in the same cycle keeps its own bit set.
- R7: A fault reported while control bit 0 (enable) is 0 is ignored. It changes no status bit, no fault address and no control bit.
- R8: A write to 0x00C with bit 0 = 1 produces a one-cycle full-flush pulse in the cycle after the write. With bit 0 = 0 the write produces no pulse.
- R9: A write to 0x010 with bit 0 = 1 produces a one-cycle single-entry flush pulse in the cycle after the write. The flush address output then carries the written value with bits [11:0] cleared.
- R10: Configuration 0x004 and table base 0x014 read back the last value written. A write to 0x014 also produces a full-flush pulse in the next cycle.
- R11: Reads of unmapped or misaligned offsets return zero, and writes to them change nothing. Writes to the read-only offsets (status, fault addresses, version) are ignored.
- R12: Read data updates in the cycle after a read strobe and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| flt_valid | input | 1 | Fault report strobe from the datapath |
| flt_type | input | 3 | Fault type, the status bit position |
| flt_addr | input | 32 | Faulting device address |
| dp_idle | input | 1 | Datapath has no request in flight |
| irq | output | 1 | Fault interrupt, OR of status bits |
| xlate_on | output | 1 | Datapath may translate |
| req_stall | output | 1 | Datapath must stall new requests |
| tlb_flush_all | output | 1 | Invalidate entire TLB (pulse) |
| tlb_flush_one | output | 1 | Invalidate one page entry (pulse) |
| tlb_flush_va | output | 32 | Page address for the single-entry flush |

## Verification
On every cycle, the assertions check the following. An accepted fault leaves the block stalled with irq raised. irq never falls except after a bus write. A full flush only follows a write. A single-entry flush address is always page aligned. Translate and stall are never both high. Other behaviour needs a sequence of accesses and can only be shown by the bench's scenarios and its per-cycle reference model. That covers which register captures each fault type, set-wins-over-clear priority, the drain handshake behind status bit 0, and reads of unmapped offsets returning zero.

// File: rtl/mmu_ctl_pkg.sv
`timescale 1ns/1ps
// Package: register offsets, control encodings and fault-to-channel routing
// shared by the MMU control register block and its checker.
package mmu_ctl_pkg;

    localparam int OFF_W = 12;

    localparam logic [OFF_W-1:0] OFF_CTRL    = 12'h000;
    localparam logic [OFF_W-1:0] OFF_CFG     = 12'h004;
    localparam logic [OFF_W-1:0] OFF_STAT    = 12'h008;
    localparam logic [OFF_W-1:0] OFF_FL_ALL  = 12'h00C;
    localparam logic [OFF_W-1:0] OFF_FL_ONE  = 12'h010;
    localparam logic [OFF_W-1:0] OFF_TBASE   = 12'h014;
    localparam logic [OFF_W-1:0] OFF_ISTAT   = 12'h018;
    localparam logic [OFF_W-1:0] OFF_ICLR    = 12'h01C;
    localparam logic [OFF_W-1:0] OFF_FA_PAGE = 12'h024;
    localparam logic [OFF_W-1:0] OFF_FA_WR   = 12'h028;
    localparam logic [OFF_W-1:0] OFF_FA_RD   = 12'h02C;
    localparam logic [OFF_W-1:0] OFF_FA_SLV  = 12'h030;
    localparam logic [OFF_W-1:0] OFF_VER     = 12'h034;

    localparam int CTRL_W      = 3;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_BK_BIT = 1;

    localparam int NUM_FAULT = 8;
    localparam int FTYPE_W   = $clog2(NUM_FAULT);
    localparam int NUM_CHAN  = 4;

    // Address capture channel a fault type lands in
    typedef enum logic [1:0] {
        CH_PAGE  = 2'd0,
        CH_WRITE = 2'd1,
        CH_READ  = 2'd2,
        CH_SLAVE = 2'd3
    } fault_chan_e;

    // Route a fault type to its address capture channel
    function automatic fault_chan_e chan_of(input logic [FTYPE_W-1:0] t);
        case (t)
            3'd0:                chan_of = CH_PAGE;
            3'd3:                chan_of = CH_SLAVE;
            3'd2, 3'd6, 3'd7:    chan_of = CH_WRITE;
            default:             chan_of = CH_READ;
        endcase
    endfunction

endpackage

// File: rtl/mmu_mode_ctl.sv
`timescale 1ns/1ps
// Module: mmu_mode_ctl
// Holds the control word and derives the translate / stall mode. An accepted
// fault forces the block bit. Tracks the drain acknowledge reported as status
// bit 0. Assumes dp_idle is synchronous to clk.
module mmu_mode_ctl
    import mmu_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wval,
    input  logic              fault_take,
    input  logic              dp_idle,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              fault_ok,
    output logic              xlate_on,
    output logic              req_stall,
    output logic              blk_ack
);
    logic [CTRL_W-1:0] ctrl_d;

    // Next control word: software write first, fault forces block on top
    always_comb begin
        ctrl_d = ctrl_we ? ctrl_wval : ctrl_q;
        if (fault_take) begin
            ctrl_d[CTRL_BK_BIT] = 1'b1;
        end
    end

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Drain acknowledge: set once stalled and idle, held until unblocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_ack <= 1'b0;
        end else begin
            blk_ack <= ctrl_q[CTRL_EN_BIT] & ctrl_q[CTRL_BK_BIT] & (blk_ack | dp_idle);
        end
    end

    assign fault_ok  = ctrl_q[CTRL_EN_BIT];
    assign xlate_on  = ctrl_q[CTRL_EN_BIT] & ~ctrl_q[CTRL_BK_BIT];
    assign req_stall = ctrl_q[CTRL_EN_BIT] &  ctrl_q[CTRL_BK_BIT];

endmodule

// File: rtl/mmu_fault_log.sv
`timescale 1ns/1ps
// Module: mmu_fault_log
// Interrupt status with write-one-to-clear, where a set beats a clear in the
// same cycle. Also holds one address capture register per fault channel.
// Assumes at most one fault is reported per cycle.
module mmu_fault_log
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fault_take,
    input  logic [FTYPE_W-1:0]               fault_type,
    input  logic [DATA_W-1:0]                fault_addr,
    input  logic                             clr_we,
    input  logic [NUM_FAULT-1:0]             clr_bits,
    output logic [NUM_FAULT-1:0]             status,
    output logic [NUM_CHAN-1:0][DATA_W-1:0]  chan_addr
);
    logic [NUM_FAULT-1:0] status_d;
    fault_chan_e          take_chan;

    assign take_chan = chan_of(fault_type);

    // Next status: clear the requested bits, then set the incoming fault bit
    always_comb begin
        status_d = clr_we ? (status & ~clr_bits) : status;
        if (fault_take) begin
            status_d[fault_type] = 1'b1;
        end
    end

    // Interrupt status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_d;
        end
    end

    // One capture register per channel, loaded with the fault address
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_addr[c] <= '0;
            end else if (fault_take && (take_chan == fault_chan_e'(c))) begin
                chan_addr[c] <= fault_addr;
            end
        end
    end

endmodule

// File: rtl/mmu_flush_gen.sv
`timescale 1ns/1ps
// Module: mmu_flush_gen
// Turns flush and table-base register writes into registered one-cycle TLB
// invalidate pulses. The single-entry address is page aligned and held
// between requests.
module mmu_flush_gen #(
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              all_req,
    input  logic              base_wr,
    input  logic              one_req,
    input  logic [DATA_W-1:0] one_va,
    output logic              flush_all,
    output logic              flush_one,
    output logic [DATA_W-1:0] flush_va
);
    localparam logic [DATA_W-1:0] PAGE_MASK = {{(DATA_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    // Pulse registers for full and single-entry invalidation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all <= 1'b0;
            flush_one <= 1'b0;
        end else begin
            flush_all <= all_req | base_wr;
            flush_one <= one_req;
        end
    end

    // Page-aligned address of the most recent single-entry request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_va <= '0;
        end else if (one_req) begin
            flush_va <= one_va & PAGE_MASK;
        end
    end

endmodule

// File: rtl/mmu_ctl_regs.sv
`timescale 1ns/1ps
// Module: mmu_ctl_regs
// Register file of a system MMU: decodes the simple register bus and owns
// the configuration and table-base words. Drives the mode, fault-log and
// flush sub-blocks, and returns read data one cycle after the strobe.
// Assumes word-aligned accesses; any other offset reads zero.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          PAGE_BITS  = 12,
    parameter logic [31:0] VERSION_ID = 32'h3000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              flt_valid,
    input  logic [2:0]        flt_type,
    input  logic [DATA_W-1:0] flt_addr,
    input  logic              dp_idle,
    output logic              irq,
    output logic              xlate_on,
    output logic              req_stall,
    output logic              tlb_flush_all,
    output logic              tlb_flush_one,
    output logic [DATA_W-1:0] tlb_flush_va
);
    localparam logic [DATA_W-1:0] VER_VAL = DATA_W'(VERSION_ID);

    logic                            ctrl_we, cfg_we, tbase_we, iclr_we;
    logic                            fl_all_we, fl_one_we;
    logic [CTRL_W-1:0]               ctrl_q;
    logic                            fault_ok, fault_take, blk_ack;
    logic [NUM_FAULT-1:0]            istat;
    logic [NUM_CHAN-1:0][DATA_W-1:0] fa_regs;
    logic [DATA_W-1:0]               cfg_q, tbase_q, rd_val;

    // Write decode: one strobe per writable offset
    always_comb begin
        ctrl_we   = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
        cfg_we    = reg_wr && (reg_addr == ADDR_W'(OFF_CFG));
        tbase_we  = reg_wr && (reg_addr == ADDR_W'(OFF_TBASE));
        iclr_we   = reg_wr && (reg_addr == ADDR_W'(OFF_ICLR));
        fl_all_we = reg_wr && (reg_addr == ADDR_W'(OFF_FL_ALL)) && reg_wdata[0];
        fl_one_we = reg_wr && (reg_addr == ADDR_W'(OFF_FL_ONE)) && reg_wdata[0];
    end

    assign fault_take = flt_valid & fault_ok;

    mmu_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wval  (reg_wdata[CTRL_W-1:0]),
        .fault_take (fault_take),
        .dp_idle    (dp_idle),
        .ctrl_q     (ctrl_q),
        .fault_ok   (fault_ok),
        .xlate_on   (xlate_on),
        .req_stall  (req_stall),
        .blk_ack    (blk_ack)
    );

    mmu_fault_log #(.DATA_W(DATA_W)) u_flog (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_take (fault_take),
        .fault_type (flt_type),
        .fault_addr (flt_addr),
        .clr_we     (iclr_we),
        .clr_bits   (reg_wdata[NUM_FAULT-1:0]),
        .status     (istat),
        .chan_addr  (fa_regs)
    );

    mmu_flush_gen #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_req   (fl_all_we),
        .base_wr   (tbase_we),
        .one_req   (fl_one_we),
        .one_va    (reg_wdata),
        .flush_all (tlb_flush_all),
        .flush_one (tlb_flush_one),
        .flush_va  (tlb_flush_va)
    );

    // Configuration and table base storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            tbase_q <= '0;
        end else begin
            if (cfg_we)   cfg_q   <= reg_wdata;
            if (tbase_we) tbase_q <= reg_wdata;
        end
    end

    // Read mux over all mapped offsets; everything else reads zero
    always_comb begin
        rd_val = '0;
        case (reg_addr)
            ADDR_W'(OFF_CTRL):    rd_val = DATA_W'(ctrl_q);
            ADDR_W'(OFF_CFG):     rd_val = cfg_q;
            ADDR_W'(OFF_STAT):    rd_val = DATA_W'(blk_ack);
            ADDR_W'(OFF_TBASE):   rd_val = tbase_q;
            ADDR_W'(OFF_ISTAT):   rd_val = DATA_W'(istat);
            ADDR_W'(OFF_FA_PAGE): rd_val = fa_regs[CH_PAGE];
            ADDR_W'(OFF_FA_WR):   rd_val = fa_regs[CH_WRITE];
            ADDR_W'(OFF_FA_RD):   rd_val = fa_regs[CH_READ];
            ADDR_W'(OFF_FA_SLV):  rd_val = fa_regs[CH_SLAVE];
            ADDR_W'(OFF_VER):     rd_val = VER_VAL;
            default:              rd_val = '0;
        endcase
    end

    // Registered read data, held between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_val;
        end
    end

    assign irq = |istat;

endmodule

// File: rtl/mmu_ctl_regs_chk.sv
`timescale 1ns/1ps
// Module: mmu_ctl_regs_chk
// Port-level protocol checks for mmu_ctl_regs, attached by bind.
module mmu_ctl_regs_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              flt_valid,
    input logic              irq,
    input logic              xlate_on,
    input logic              req_stall,
    input logic              tlb_flush_all,
    input logic              tlb_flush_one,
    input logic [DATA_W-1:0] tlb_flush_va
);
    // R4: an accepted fault leaves the block stalled with irq raised
    a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && (xlate_on || req_stall)) |=> (req_stall && irq));

    // R6: pending interrupts only go away through a bus write
    a_r6_irq_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr));

    // R8: a full flush pulse always follows a bus write
    a_r8_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> $past(reg_wr));

    // R9: single-entry flush address is page aligned
    a_r9_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_one |-> (tlb_flush_va[11:0] == 12'h000));

    // R2: translate and stall are exclusive modes
    a_r2_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlate_on && req_stall));
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .flt_valid     (flt_valid),
    .irq           (irq),
    .xlate_on      (xlate_on),
    .req_stall     (req_stall),
    .tlb_flush_all (tlb_flush_all),
    .tlb_flush_one (tlb_flush_one),
    .tlb_flush_va  (tlb_flush_va)
);

// File: tb/mmu_ctl_regs_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed
// register scenarios.
module mmu_ctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        dp_idle = 1'b0;
    logic        irq, xlate_on, req_stall, tlb_flush_all, tlb_flush_one;
    logic [31:0] tlb_flush_va;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mmu_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
        .dp_idle(dp_idle), .irq(irq), .xlate_on(xlate_on), .req_stall(req_stall),
        .tlb_flush_all(tlb_flush_all), .tlb_flush_one(tlb_flush_one),
        .tlb_flush_va(tlb_flush_va)
    );

    // ---------------- reference model ----------------
    int unsigned m_ctrl, m_cfg, m_tb, m_stat, m_rd, m_fva;
    int unsigned m_fa[4];
    bit m_ack, m_fall, m_fone;

    function automatic int unsigned m_read(input int unsigned a);
        case (a)
            'h000: return m_ctrl;
            'h004: return m_cfg;
            'h008: return m_ack;
            'h014: return m_tb;
            'h018: return m_stat;
            'h024: return m_fa[0];
            'h028: return m_fa[1];
            'h02C: return m_fa[2];
            'h030: return m_fa[3];
            'h034: return 32'h3000_0001;
            default: return 0;
        endcase
    endfunction

    function automatic int slot(input int t);
        if (t == 0) return 0;
        if (t == 3) return 3;
        if (t == 2 || t == 6 || t == 7) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cfg = 0; m_tb = 0; m_stat = 0; m_rd = 0; m_fva = 0;
            m_ack = 0; m_fall = 0; m_fone = 0;
            foreach (m_fa[i]) m_fa[i] = 0;
        end else begin
            bit take;
            int unsigned nctrl, nstat, nrd;
            bit nack;
            take  = flt_valid && m_ctrl[0];
            nrd   = reg_rd ? m_read(reg_addr) : m_rd;
            nack  = m_ctrl[0] && m_ctrl[1] && (m_ack || dp_idle);
            nctrl = (reg_wr && reg_addr == 'h000) ? (reg_wdata & 7) : m_ctrl;
            nstat = (reg_wr && reg_addr == 'h01C) ? (m_stat & ~(reg_wdata & 'hFF)) : m_stat;
            if (take) begin
                nctrl = nctrl | 2;
                nstat = nstat | (1 << flt_type);
                m_fa[slot(flt_type)] = flt_addr;
            end
            m_fall = reg_wr && ((reg_addr == 'h00C && reg_wdata[0]) || reg_addr == 'h014);
            m_fone = reg_wr && reg_addr == 'h010 && reg_wdata[0];
            if (m_fone) m_fva = reg_wdata & 32'hFFFF_F000;
            if (reg_wr && reg_addr == 'h004) m_cfg = reg_wdata;
            if (reg_wr && reg_addr == 'h014) m_tb = reg_wdata;
            m_ctrl = nctrl; m_stat = nstat; m_ack = nack; m_rd = nrd;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R4 irq", {31'b0, irq}, {31'b0, m_stat != 0});
            chk("R2 xlate_on", {31'b0, xlate_on}, {31'b0, m_ctrl[0] && !m_ctrl[1]});
            chk("R2 req_stall", {31'b0, req_stall}, {31'b0, m_ctrl[0] && m_ctrl[1]});
            chk("R8 flush_all", {31'b0, tlb_flush_all}, {31'b0, m_fall});
            chk("R9 flush_one", {31'b0, tlb_flush_one}, {31'b0, m_fone});
            chk("R9 flush_va", tlb_flush_va, m_fva);
            chk("R12 rdata", reg_rdata, m_rd);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic fault(input logic [2:0] t, input logic [31:0] a);
        @(negedge clk); flt_valid = 1; flt_type = t; flt_addr = a;
        @(negedge clk); flt_valid = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 flush", {30'b0, tlb_flush_all, tlb_flush_one}, 0);
        rd_chk('h000, 0, "R1 ctrl");
        rd_chk('h018, 0, "R1 istat");
        rd_chk('h034, 32'h3000_0001, "R1 version");
        // R7 fault while disabled
        fault(3'd0, 32'h0000_1111);
        rd_chk('h018, 0, "R7 status untouched");
        rd_chk('h024, 0, "R7 address untouched");
        // R2 enable
        wr('h000, 32'h5);
        rd_chk('h000, 5, "R2 ctrl readback");
        chk("R2 translating", {31'b0, xlate_on}, 1);
        // R4 / R5 fault forces block
        fault(3'd5, 32'h1234_5678);
        chk("R4 irq high", {31'b0, irq}, 1);
        rd_chk('h018, 32'h20, "R4 status bit5");
        rd_chk('h000, 7, "R4 block forced");
        rd_chk('h02C, 32'h1234_5678, "R5 read channel");
        // R3 drain handshake
        rd_chk('h008, 0, "R3 not idle");
        @(negedge clk); dp_idle = 1;
        @(negedge clk); @(negedge clk);
        rd_chk('h008, 1, "R3 block done");
        // R5 routing for the other channels
        fault(3'd3, 32'hDEAD_0030);
        fault(3'd7, 32'h0BAD_0028);
        fault(3'd0, 32'h00C0_FFEE);
        fault(3'd1, 32'h1111_0000);
        rd_chk('h030, 32'hDEAD_0030, "R5 slave channel");
        rd_chk('h028, 32'h0BAD_0028, "R5 write channel");
        rd_chk('h024, 32'h00C0_FFEE, "R5 page channel");
        rd_chk('h02C, 32'h1111_0000, "R5 read channel overwrite");
        rd_chk('h018, 32'hAB, "R4 accumulated status");
        // R6 clear and set-wins
        wr('h01C, 32'h20);
        rd_chk('h018, 32'h8B, "R6 clear bit5");
        @(negedge clk);
        reg_wr = 1; reg_addr = 'h01C; reg_wdata = 32'h01;
        flt_valid = 1; flt_type = 3'd0; flt_addr = 32'h00C0_FFEE;
        @(negedge clk); reg_wr = 0; flt_valid = 0;
        rd_chk('h018, 32'h8B, "R6 set wins over clear");
        wr('h01C, 32'hFF);
        chk("R6 irq cleared", {31'b0, irq}, 0);
        // R3 unblock drops status bit 0
        wr('h000, 32'h5);
        @(negedge clk);
        rd_chk('h008, 0, "R3 ack dropped");
        // R8 / R9 / R10 flushes
        wr('h00C, 32'h1);
        chk("R8 full flush pulse", {31'b0, tlb_flush_all}, 1);
        wr('h00C, 32'h0);
        chk("R8 no pulse for bit0=0", {31'b0, tlb_flush_all}, 0);
        wr('h010, 32'h1234_5ABD);
        chk("R9 entry pulse", {31'b0, tlb_flush_one}, 1);
        chk("R9 entry address", tlb_flush_va, 32'h1234_5000);
        wr('h014, 32'hABCD_0000);
        chk("R10 base flush", {31'b0, tlb_flush_all}, 1);
        rd_chk('h014, 32'hABCD_0000, "R10 table base");
        wr('h004, 32'h1000_1001);
        rd_chk('h004, 32'h1000_1001, "R10 config");
        // R11 unmapped and read-only
        wr('h040, 32'hFFFF_FFFF);
        rd_chk('h040, 0, "R11 unmapped read");
        rd_chk('h002, 0, "R11 misaligned read");
        wr('h024, 32'h55);
        rd_chk('h024, 32'h00C0_FFEE, "R11 fault address read-only");
        wr('h034, 32'h0);
        rd_chk('h034, 32'h3000_0001, "R11 version read-only");
        // R12 hold
        repeat (3) @(negedge clk);
        chk("R12 rdata held", reg_rdata, 32'h3000_0001);
        // Random traffic checked by the model
        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            @(negedge clk);
            pick = $urandom_range(0, 13);
            reg_addr = (pick == 13) ? 12'h002 : 12'(pick * 4);
            if (pick == 0) reg_wdata = (($urandom % 2) == 0) ? 32'h5 : 32'h7;
            else reg_wdata = $urandom;
            reg_wr = ($urandom % 3) == 0;
            reg_rd = ($urandom % 2) == 0;
            flt_valid = ($urandom % 5) == 0;
            flt_type = 3'($urandom);
            flt_addr = $urandom;
            dp_idle = ($urandom % 4) != 0;
        end
        @(negedge clk); reg_wr = 0; reg_rd = 0; flt_valid = 0;
        // R7 again after disabling
        wr('h01C, 32'hFF);
        wr('h000, 32'h0);
        fault(3'd6, 32'h7777_7777);
        rd_chk('h018, 0, "R7 disabled fault ignored");
        rd_chk('h000, 0, "R7 control untouched");
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule